// File: doc/BRIEF.md
# Segment-Encoded Decade Counter

This block counts the ones digit of a clock's minutes from zero to nine and back to zero. The state register holds the seven-segment pattern itself, so its flip-flops drive the display lines directly. No binary count is kept and no decoder sits between the register and the lamps. Each enabled clock edge moves the display to the next digit. When the digit steps from nine to zero, a carry output tells the tens digit to advance.

A one-minute tick drives the count-enable input. While the enable is low the pattern holds. Reset loads the pattern for zero. That pattern is not all zeros, so reset sets six flip-flops and clears one. Once reset is released, the register loads the next-state value on every enabled edge.

Top module: `seg_decade_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register loads the zero pattern. `seg_out` is then 7'b1111110, with bit 6 = segment A down to bit 0 = segment G and 1 = lit.
- R2: On each rising edge with `rst` low and `tick_en` high, the pattern advances one digit. The patterns are 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 8=1111111, 9=1111011.
- R3: The digit seven is 1110000. The step from six goes to seven, and the next enabled step goes to eight.
- R4: On a rising edge with `rst` low and `tick_en` low, `seg_out` keeps its value.
- R5: `carry_out` is high exactly when `tick_en` is high and `seg_out` shows nine. It is combinational, so it is high for one enabled cycle.
- R6: An enabled edge while nine is shown returns `seg_out` to the zero pattern 1111110.
- R7: `rst` takes priority over `tick_en`. A reset in the middle of a count returns the display to zero on that edge, whatever the enable.
- R8: After reset the register only ever holds one of the ten digit patterns. Any other pattern would be replaced by the zero pattern on the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, loads the zero pattern |
| tick_en | input | 1 | Count enable; one-cycle tick advances the digit |
| seg_out | output | 7 | Segment lines, bit 6 = A ... bit 0 = G, 1 = lit |
| carry_out | output | 1 | High while enabled on nine; advances the tens digit |

## Verification
`seg_out` is a register output. A change of `tick_en` or `rst` applied before an edge is visible one edge later, so the bench drives its inputs at the falling edge, lets the rising edge pass, and compares the pattern at the next falling edge. `carry_out` depends only on `tick_en` and the current pattern, so it is due in the same cycle as the enable. The bench checks it a moment after driving the inputs and before the rising edge. The reference model is an integer digit. It is stepped at each rising edge from the requirements, and its expected pattern comes from a written-out digit table.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int unsigned SEG_W      = 7;
    localparam int unsigned NUM_DIGITS = 10;

    typedef logic [SEG_W-1:0] seg_t;

    // Bit 6 = A ... bit 0 = G, 1 = lit.
    localparam seg_t SEG_ZERO = 7'b1111110;

    typedef struct packed {
        logic [NUM_DIGITS-1:0] hit;   // one-hot: current pattern equals digit d
        logic                  legal; // any digit matched
    } match_t;

    function automatic seg_t digit_pattern(input int unsigned d);
        case (d)
            0:       digit_pattern = 7'b1111110;
            1:       digit_pattern = 7'b0110000;
            2:       digit_pattern = 7'b1101101;
            3:       digit_pattern = 7'b1111001;
            4:       digit_pattern = 7'b0110011;
            5:       digit_pattern = 7'b1011011;
            6:       digit_pattern = 7'b1011111;
            7:       digit_pattern = 7'b1110000;
            8:       digit_pattern = 7'b1111111;
            9:       digit_pattern = 7'b1111011;
            default: digit_pattern = SEG_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/seg_match_bank.sv
module seg_match_bank
    import seg_pkg::*;
(
    input  seg_t   cur,
    output match_t match
);
    logic [NUM_DIGITS-1:0] hit;

    // One comparator per digit pattern.
    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_cmp
        localparam seg_t PAT = digit_pattern(d);
        assign hit[d] = (cur == PAT);
    end

    assign match.hit   = hit;
    assign match.legal = |hit;
endmodule

// File: rtl/seg_next_select.sv
module seg_next_select
    import seg_pkg::*;
(
    input  match_t match,
    output seg_t   nxt,
    output logic   at_last
);
    always_comb begin
        nxt = SEG_ZERO;  // unmatched patterns recover to zero
        for (int unsigned d = 0; d < NUM_DIGITS; d++) begin
            if (match.hit[d])
                nxt = digit_pattern((d + 1) % NUM_DIGITS);
        end
    end

    assign at_last = match.hit[NUM_DIGITS-1];
endmodule

// File: rtl/seg_state_reg.sv
module seg_state_reg
    import seg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  seg_t d,
    output seg_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= SEG_ZERO;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/seg_decade_counter.sv
module seg_decade_counter
    import seg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [SEG_W-1:0] seg_out,
    output logic             carry_out
);
    seg_t   state;
    seg_t   nxt;
    match_t match;
    logic   at_last;

    seg_match_bank u_match (
        .cur   (state),
        .match (match)
    );

    seg_next_select u_next (
        .match   (match),
        .nxt     (nxt),
        .at_last (at_last)
    );

    seg_state_reg u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (tick_en),
        .d    (nxt),
        .q    (state)
    );

    assign seg_out   = state;
    assign carry_out = tick_en & at_last;
endmodule

// File: rtl/seg_decade_counter_chk.sv
module seg_decade_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_en,
    input logic [6:0] seg_out,
    input logic       carry_out
);
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> seg_out == 7'b1111110);

    p_legal_state_r8: assert property (@(posedge clk) disable iff (rst)
        seg_out inside {7'b1111110, 7'b0110000, 7'b1101101, 7'b1111001,
                        7'b0110011, 7'b1011011, 7'b1011111, 7'b1110000,
                        7'b1111111, 7'b1111011});

    p_one_to_two_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && seg_out == 7'b0110000) |=> seg_out == 7'b1101101);

    p_six_to_seven_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_en && seg_out == 7'b1011111) |=> seg_out == 7'b1110000);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(seg_out));

    p_carry_r5: assert property (@(posedge clk) disable iff (rst)
        carry_out == (tick_en && seg_out == 7'b1111011));

    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        carry_out |=> seg_out == 7'b1111110);
endmodule

bind seg_decade_counter seg_decade_counter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .seg_out   (seg_out),
    .carry_out (carry_out)
);

// File: tb/seg_decade_counter_test.sv
module seg_decade_counter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [6:0] seg_out;
    logic       carry_out;

    int vectors = 0;
    int errors  = 0;
    int digit   = 0;   // reference model state
    bit done    = 0;

    always #4 clk = ~clk;  // 125 MHz

    seg_decade_counter uut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .seg_out   (seg_out),
        .carry_out (carry_out)
    );

    function automatic logic [6:0] ref_pat(input int dg);
        case (dg)
            0: return 7'b1111110;
            1: return 7'b0110000;
            2: return 7'b1101101;
            3: return 7'b1111001;
            4: return 7'b0110011;
            5: return 7'b1011011;
            6: return 7'b1011111;
            7: return 7'b1110000;
            8: return 7'b1111111;
            default: return 7'b1111011;
        endcase
    endfunction

    function automatic string req_of(input int prev, input bit r, input bit e);
        if (r)                      return "R1/R7";
        if (!e)                     return "R4";
        if (prev == 9)              return "R6";
        if (prev == 6 || prev == 7) return "R3";
        return "R2";
    endfunction

    // One clock: drive at falling edge, check carry before the rising
    // edge, step model at the rising edge, check pattern one edge later.
    task automatic step(input bit r, input bit e);
        logic       exp_c;
        int         prev;
        string      rq;
        rst     = r;
        tick_en = e;
        #1;
        exp_c = e && (digit == 9);
        vectors++;
        if (carry_out !== exp_c) begin
            errors++;
            $display("FAIL R5: carry_out=%b expected %b (digit %0d)", carry_out, exp_c, digit);
        end
        prev = digit;
        @(posedge clk);
        if (r)      digit = 0;
        else if (e) digit = (digit + 1) % 10;
        @(negedge clk);
        rq = req_of(prev, r, e);
        vectors++;
        if (seg_out !== ref_pat(digit)) begin
            errors++;
            $display("FAIL %s: seg_out=%b expected %b", rq, seg_out, ref_pat(digit));
        end
    endtask

    initial begin
        @(negedge clk);
        step(1, 0);                                 // R1 reset state
        step(1, 1);                                 // R7 reset beats enable
        for (int i = 0; i < 25; i++) step(0, 1);    // R2 R3 R6 full laps
        for (int i = 0; i < 6; i++)  step(0, 0);    // R4 hold
        for (int i = 0; i < 30; i++) step(0, i % 2 == 0);  // sparse ticks
        for (int i = 0; i < 12; i++) step(0, (i % 3) != 1);
        step(1, 1);                                 // R7 mid-count reset
        for (int i = 0; i < 9; i++)  step(0, 1);    // reach nine
        for (int i = 0; i < 3; i++)  step(0, 0);    // R5 no carry while idle on nine
        step(0, 1);                                 // R5 R6 wrap
        for (int i = 0; i < 4; i++)  step(0, 1);
        step(1, 0);
        step(0, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule